// File: doc/BRIEF.md
# Audio Channel Sample FIFO with Threshold Requests

This block buffers the samples of a single audio channel between a producer and a consumer that share one clock. It stores up to 32 samples of 24 bits. Both ports use valid/ready handshakes. The block sits on either side of a rate converter, and a parameter sets which side it serves. On the output side it asks for service when enough samples are waiting to be drained. On the input side it asks for service when enough room is free to be refilled.

Software writes a threshold between 1 and 16 samples. Any value outside that range is pulled to the nearest limit. The block compares the fill level against this threshold and drives a level-sensitive DMA request. It also drives an interrupt request, gated by an enable bit. Two comparison outputs, one for fill and one for free space, feed a group aggregator that combines several channels.

A push into a full buffer is dropped and sets a sticky overflow flag. A pop from an empty buffer returns zero and sets a sticky underflow flag. Either flag raises the error interrupt. The flags stay set until software writes 1 to their bits. A flush input empties the buffer and leaves the flags untouched.

Top module: `chan_sample_fifo`

## Requirements
- R1: After reset the level is 0, wr_ready is 1, rd_valid is 0, thr_q is 8, both error flags are 0, irq_en is off and irq is 0.
- R2: Samples leave in the order they entered. level counts the stored samples from 0 to 32. wr_ready is 0 exactly when level is 32, and rd_valid is 1 exactly when level is nonzero.
- R3: A cfg_wr pulse loads thr_q from cfg_thr clamped into 1..16: a value of 0 becomes 1, any value above 16 becomes 16, and values from 1 to 16 are kept.
- R4: With DIR set to the output variant, dma_req is 1 exactly when level >= thr_q, in the same cycle.
- R5: With DIR set to the input variant, dma_req is 1 exactly when 32 - level >= thr_q.
- R6: irq equals dma_req AND the enable bit. The enable bit is loaded from cfg_irq_en on a cfg_wr pulse.
- R7: wr_valid while level is 32 stores nothing, leaves level at 32 and sets err_ovf, which stays set.
- R8: rd_ready while level is 0 shows rd_data = 0, changes no pointer and sets err_unf, which stays set.
- R9: err_irq equals err_ovf OR err_unf.
- R10: An err_clr_wr pulse clears err_ovf when err_clr bit 0 is 1 and clears err_unf when err_clr bit 1 is 1. A new error event in the same cycle wins over the clear.
- R11: flush empties the buffer (level becomes 0) on the next edge and keeps both error flags.
- R12: fill_ge_thr is (level >= thr_q) and space_ge_thr is (32 - level >= thr_q), in both variants.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Empty the buffer; error flags are kept |
| wr_valid | input | 1 | Producer offers a sample |
| wr_data | input | 24 | Sample to store |
| wr_ready | output | 1 | Room is available |
| rd_ready | input | 1 | Consumer takes a sample |
| rd_valid | output | 1 | A sample is available |
| rd_data | output | 24 | Oldest sample, or 0 when empty |
| cfg_wr | input | 1 | Load the threshold and the interrupt enable |
| cfg_thr | input | 5 | Requested threshold, clamped to 1..16 |
| cfg_irq_en | input | 1 | Interrupt enable value |
| err_clr_wr | input | 1 | Apply the write-1-to-clear mask |
| err_clr | input | 2 | Bit 0 clears overflow, bit 1 clears underflow |
| level | output | 6 | Number of stored samples |
| thr_q | output | 5 | Threshold in effect |
| err_ovf | output | 1 | Sticky overflow flag |
| err_unf | output | 1 | Sticky underflow flag |
| fill_ge_thr | output | 1 | Level is at least the threshold |
| space_ge_thr | output | 1 | Free space is at least the threshold |
| dma_req | output | 1 | Level-sensitive service request |
| irq | output | 1 | Service interrupt, gated by the enable |
| err_irq | output | 1 | Error interrupt |

## Verification
The bench writes every threshold code from 0 to 31 and checks the clamp. For each threshold from 1 to 16 it steps the level from 0 up to 32 and checks both variants. An off-by-one compare or a swapped fill/space sense would then show up at a single level. It pushes into a full buffer and then drains it, so a design that overwrote the oldest sample or moved a pointer would return the wrong first word. It also pops from an empty buffer and then pushes and pops one sample, which catches a read pointer that slips on underflow. It issues a clear in the same cycle as a new overflow, and it flushes while a flag is set. These cases catch a clear that wins over a set and a flush that wipes the flags.

// File: rtl/csf_pkg.sv
package csf_pkg;

   typedef enum logic {
      CSF_DIR_IN  = 1'b0,
      CSF_DIR_OUT = 1'b1
   } csf_dir_e;

   typedef struct packed {
      logic unf;
      logic ovf;
   } csf_err_t;

endpackage

// File: rtl/csf_store.sv
module csf_store #(
   parameter int DW    = 24,
   parameter int DEPTH = 32,
   parameter int AW    = 5,
   parameter int LW    = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          flush,
   input  logic          wr_valid,
   input  logic [DW-1:0] wr_data,
   output logic          wr_ready,
   input  logic          rd_ready,
   output logic          rd_valid,
   output logic [DW-1:0] rd_data,
   output logic [LW-1:0] level,
   output logic          ovf_evt,
   output logic          unf_evt
);

   localparam logic [LW-1:0] FULL_L = LW'(DEPTH);

   logic [AW-1:0] wptr, rptr;
   logic [LW-1:0] cnt;
   logic [DW-1:0] mem [DEPTH];
   logic          full, empty, wr_fire, rd_fire;

   assign full    = (cnt == FULL_L);
   assign empty   = (cnt == '0);
   assign wr_fire = wr_valid && !full && !flush;
   assign rd_fire = rd_ready && !empty && !flush;
   assign ovf_evt = wr_valid && full && !flush;
   assign unf_evt = rd_ready && empty && !flush;

   assign wr_ready = !full;
   assign rd_valid = !empty;
   assign rd_data  = empty ? '0 : mem[rptr];
   assign level    = cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr <= '0;
         rptr <= '0;
         cnt  <= '0;
      end else if (flush) begin
         wptr <= '0;
         rptr <= '0;
         cnt  <= '0;
      end else begin
         if (wr_fire) wptr <= wptr + 1'b1;
         if (rd_fire) rptr <= rptr + 1'b1;
         case ({wr_fire, rd_fire})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (wr_fire) mem[wptr] <= wr_data;
   end

   assert_level_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
      level <= FULL_L);

   assert_full_blocks_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (level == FULL_L) |-> !wr_ready);

   assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && !wr_ready && !rd_ready && !flush) |=> (level == $past(level)));

   assert_underflow_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_ready && !rd_valid && !wr_valid && !flush) |=> (level == '0));

   assert_empty_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_valid |-> (rd_data == '0));

   assert_flush_empty_R11: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (level == '0));

endmodule

// File: rtl/csf_thresh.sv
module csf_thresh
   import csf_pkg::*;
#(
   parameter int       DEPTH   = 32,
   parameter int       TMAX    = 16,
   parameter int       TW      = 5,
   parameter int       LW      = 6,
   parameter int       THR_RST = 8,
   parameter csf_dir_e DIR     = CSF_DIR_OUT
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cfg_wr,
   input  logic [TW-1:0] cfg_thr,
   input  logic          cfg_irq_en,
   input  logic [LW-1:0] level,
   output logic [TW-1:0] thr_q,
   output logic          irq_en,
   output logic          fill_ge,
   output logic          space_ge,
   output logic          req
);

   localparam logic [TW-1:0] TMAX_T = TW'(TMAX);
   localparam logic [TW-1:0] TRST_T = TW'(THR_RST);
   localparam logic [LW-1:0] FULL_L = LW'(DEPTH);

   logic [TW-1:0] thr_clamped;
   logic [LW-1:0] space, thr_l;

   always_comb begin
      if (cfg_thr == '0)         thr_clamped = TW'(1);
      else if (cfg_thr > TMAX_T) thr_clamped = TMAX_T;
      else                       thr_clamped = cfg_thr;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         thr_q  <= TRST_T;
         irq_en <= 1'b0;
      end else if (cfg_wr) begin
         thr_q  <= thr_clamped;
         irq_en <= cfg_irq_en;
      end
   end

   assign thr_l    = LW'(thr_q);
   assign space    = FULL_L - level;
   assign fill_ge  = (level >= thr_l);
   assign space_ge = (space >= thr_l);

   generate
      if (DIR == CSF_DIR_OUT) begin : g_out
         assign req = fill_ge;
      end else begin : g_in
         assign req = space_ge;
      end
   endgenerate

   assert_thr_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (thr_q >= TW'(1)) && (thr_q <= TMAX_T));

   assert_clamp_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_wr && cfg_thr == '0) |=> (thr_q == TW'(1)));

   assert_clamp_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_wr && cfg_thr > TMAX_T) |=> (thr_q == TMAX_T));

endmodule

// File: rtl/csf_errflags.sv
module csf_errflags
   import csf_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ovf_evt,
   input  logic       unf_evt,
   input  logic       clr_wr,
   input  logic [1:0] clr,
   output csf_err_t   flags
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flags <= '0;
      end else begin
         if (ovf_evt)                flags.ovf <= 1'b1;
         else if (clr_wr && clr[0])  flags.ovf <= 1'b0;
         if (unf_evt)                flags.unf <= 1'b1;
         else if (clr_wr && clr[1])  flags.unf <= 1'b0;
      end
   end

   assert_ovf_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_evt |=> flags.ovf);

   assert_unf_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
      unf_evt |=> flags.unf);

   assert_ovf_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (flags.ovf && !(clr_wr && clr[0])) |=> flags.ovf);

   assert_unf_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (flags.unf && !(clr_wr && clr[1])) |=> flags.unf);

endmodule

// File: rtl/chan_sample_fifo.sv
module chan_sample_fifo
   import csf_pkg::*;
#(
   parameter int       DW      = 24,
   parameter int       DEPTH   = 32,
   parameter int       TMAX    = 16,
   parameter int       THR_RST = 8,
   parameter csf_dir_e DIR     = CSF_DIR_OUT,
   localparam int      AW      = $clog2(DEPTH),
   localparam int      LW      = AW + 1,
   localparam int      TW      = $clog2(TMAX + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          flush,
   input  logic          wr_valid,
   input  logic [DW-1:0] wr_data,
   output logic          wr_ready,
   input  logic          rd_ready,
   output logic          rd_valid,
   output logic [DW-1:0] rd_data,
   input  logic          cfg_wr,
   input  logic [TW-1:0] cfg_thr,
   input  logic          cfg_irq_en,
   input  logic          err_clr_wr,
   input  logic [1:0]    err_clr,
   output logic [LW-1:0] level,
   output logic [TW-1:0] thr_q,
   output logic          err_ovf,
   output logic          err_unf,
   output logic          fill_ge_thr,
   output logic          space_ge_thr,
   output logic          dma_req,
   output logic          irq,
   output logic          err_irq
);

   generate
      if ((1 << AW) != DEPTH) begin : g_bad_depth
         $error("DEPTH must be a power of two");
      end
      if (TMAX < 1 || TMAX > DEPTH) begin : g_bad_tmax
         $error("TMAX must lie in 1..DEPTH");
      end
      if (THR_RST < 1 || THR_RST > TMAX) begin : g_bad_trst
         $error("THR_RST must lie in 1..TMAX");
      end
      if (TW >= LW + 1) begin : g_bad_tw
         $error("threshold field wider than level field");
      end
   endgenerate

   logic     ovf_evt, unf_evt, irq_en;
   csf_err_t flags;

   csf_store #(.DW(DW), .DEPTH(DEPTH), .AW(AW), .LW(LW)) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .flush    (flush),
      .wr_valid (wr_valid),
      .wr_data  (wr_data),
      .wr_ready (wr_ready),
      .rd_ready (rd_ready),
      .rd_valid (rd_valid),
      .rd_data  (rd_data),
      .level    (level),
      .ovf_evt  (ovf_evt),
      .unf_evt  (unf_evt)
   );

   csf_thresh #(.DEPTH(DEPTH), .TMAX(TMAX), .TW(TW), .LW(LW),
                .THR_RST(THR_RST), .DIR(DIR)) u_thresh (
      .clk        (clk),
      .rst_n      (rst_n),
      .cfg_wr     (cfg_wr),
      .cfg_thr    (cfg_thr),
      .cfg_irq_en (cfg_irq_en),
      .level      (level),
      .thr_q      (thr_q),
      .irq_en     (irq_en),
      .fill_ge    (fill_ge_thr),
      .space_ge   (space_ge_thr),
      .req        (dma_req)
   );

   csf_errflags u_err (
      .clk    (clk),
      .rst_n  (rst_n),
      .ovf_evt(ovf_evt),
      .unf_evt(unf_evt),
      .clr_wr (err_clr_wr),
      .clr    (err_clr),
      .flags  (flags)
   );

   assign err_ovf = flags.ovf;
   assign err_unf = flags.unf;
   assign err_irq = flags.ovf | flags.unf;
   assign irq     = irq_en & dma_req;

   assert_irq_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> dma_req);

   assert_err_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (err_ovf || err_unf) |-> err_irq);

endmodule

// File: tb/chan_sample_fifo_bench.sv
module chan_sample_fifo_bench;
   import csf_pkg::*;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        flush = 1'b0;
   logic        wr_valid = 1'b0;
   logic [23:0] wr_data = '0;
   logic        rd_ready = 1'b0;
   logic        cfg_wr = 1'b0;
   logic [4:0]  cfg_thr = '0;
   logic        cfg_irq_en = 1'b0;
   logic        err_clr_wr = 1'b0;
   logic [1:0]  err_clr = '0;

   logic        o_wr_ready, o_rd_valid, o_ovf, o_unf, o_fge, o_sge, o_req, o_irq, o_eirq;
   logic [23:0] o_rd_data;
   logic [5:0]  o_level;
   logic [4:0]  o_thr;
   logic        i_wr_ready, i_rd_valid, i_ovf, i_unf, i_fge, i_sge, i_req, i_irq, i_eirq;
   logic [23:0] i_rd_data;
   logic [5:0]  i_level;
   logic [4:0]  i_thr;

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   chan_sample_fifo #(.DIR(CSF_DIR_OUT)) u_chan_sample_fifo (
      .clk(clk), .rst_n(rst_n), .flush(flush),
      .wr_valid(wr_valid), .wr_data(wr_data), .wr_ready(o_wr_ready),
      .rd_ready(rd_ready), .rd_valid(o_rd_valid), .rd_data(o_rd_data),
      .cfg_wr(cfg_wr), .cfg_thr(cfg_thr), .cfg_irq_en(cfg_irq_en),
      .err_clr_wr(err_clr_wr), .err_clr(err_clr),
      .level(o_level), .thr_q(o_thr), .err_ovf(o_ovf), .err_unf(o_unf),
      .fill_ge_thr(o_fge), .space_ge_thr(o_sge), .dma_req(o_req),
      .irq(o_irq), .err_irq(o_eirq));

   chan_sample_fifo #(.DIR(CSF_DIR_IN)) u_in (
      .clk(clk), .rst_n(rst_n), .flush(flush),
      .wr_valid(wr_valid), .wr_data(wr_data), .wr_ready(i_wr_ready),
      .rd_ready(rd_ready), .rd_valid(i_rd_valid), .rd_data(i_rd_data),
      .cfg_wr(cfg_wr), .cfg_thr(cfg_thr), .cfg_irq_en(cfg_irq_en),
      .err_clr_wr(err_clr_wr), .err_clr(err_clr),
      .level(i_level), .thr_q(i_thr), .err_ovf(i_ovf), .err_unf(i_unf),
      .fill_ge_thr(i_fge), .space_ge_thr(i_sge), .dma_req(i_req),
      .irq(i_irq), .err_irq(i_eirq));

   function automatic logic [23:0] pat(int k);
      return 24'(k * 24'h013579) ^ 24'h5A5A5A;
   endfunction

   task automatic check(input string req, input longint act, input longint exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic push(input logic [23:0] d);
      wr_valid = 1'b1;
      wr_data  = d;
      tick();
      wr_valid = 1'b0;
   endtask

   task automatic set_cfg(input int v, input logic en);
      cfg_wr     = 1'b1;
      cfg_thr    = 5'(v);
      cfg_irq_en = en;
      tick();
      cfg_wr = 1'b0;
   endtask

   task automatic do_flush();
      flush = 1'b1;
      tick();
      flush = 1'b0;
   endtask

   initial begin
      #(8 * 200000);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      tick();

      // R1 reset state
      check("R1 level", o_level, 0);
      check("R1 wr_ready", o_wr_ready, 1);
      check("R1 rd_valid", o_rd_valid, 0);
      check("R1 thr", o_thr, 8);
      check("R1 errors", {o_ovf, o_unf, i_ovf, i_unf}, 0);
      check("R1 irq", {o_irq, i_irq}, 0);

      // R3 clamp sweep over every code
      for (int v = 0; v < 32; v++) begin
         set_cfg(v, 1'b0);
         check("R3 clamp", o_thr, (v == 0) ? 1 : (v > 16) ? 16 : v);
         check("R3 clamp in", i_thr, (v == 0) ? 1 : (v > 16) ? 16 : v);
      end

      // R4 R5 R12 R2 threshold x level sweep
      for (int t = 1; t <= 16; t++) begin
         set_cfg(t, 1'b0);
         do_flush();
         for (int n = 0; n <= 32; n++) begin
            check("R2 level", o_level, n);
            check("R2 wr_ready", o_wr_ready, (n < 32) ? 1 : 0);
            check("R2 rd_valid", o_rd_valid, (n > 0) ? 1 : 0);
            check("R4 out req", o_req, (n >= t) ? 1 : 0);
            check("R5 in req", i_req, ((32 - n) >= t) ? 1 : 0);
            check("R12 fill", o_fge, (n >= t) ? 1 : 0);
            check("R12 space", i_sge, ((32 - n) >= t) ? 1 : 0);
            check("R12 fill in", i_fge, (n >= t) ? 1 : 0);
            if (n < 32) push(pat(n));
         end
      end

      // R6 interrupt gating
      do_flush();
      set_cfg(4, 1'b1);
      check("R6 out irq empty", o_irq, 0);
      check("R6 in irq empty", i_irq, 1);
      for (int k = 0; k < 4; k++) push(pat(k));
      check("R6 out irq at thr", o_irq, 1);
      set_cfg(4, 1'b0);
      check("R6 out irq disabled", o_irq, 0);
      check("R6 in irq disabled", i_irq, 0);

      // R7 overflow on full buffer
      do_flush();
      for (int k = 0; k < 32; k++) push(pat(k));
      check("R7 no err before", o_ovf, 0);
      push(24'hFFFFFF);
      check("R7 ovf set", o_ovf, 1);
      check("R7 level held", o_level, 32);
      check("R9 err_irq ovf", o_eirq, 1);
      check("R8 unf untouched", o_unf, 0);
      tick();
      check("R7 ovf sticky", o_ovf, 1);

      // R2 order, and dropped word not stored
      for (int k = 0; k < 32; k++) begin
         rd_ready = 1'b1;
         #1;
         check("R2 order", o_rd_data, pat(k));
         tick();
         rd_ready = 1'b0;
      end
      check("R2 drained", o_level, 0);

      // R8 underflow
      rd_ready = 1'b1;
      #1;
      check("R8 zero data", o_rd_data, 0);
      tick();
      rd_ready = 1'b0;
      check("R8 unf set", o_unf, 1);
      check("R8 level", o_level, 0);
      push(24'h123456);
      rd_ready = 1'b1;
      #1;
      check("R8 pointers kept", o_rd_data, 24'h123456);
      tick();
      rd_ready = 1'b0;
      check("R8 level after", o_level, 0);

      // R10 write-1-to-clear
      err_clr_wr = 1'b1;
      err_clr    = 2'b01;
      tick();
      err_clr_wr = 1'b0;
      check("R10 ovf cleared", o_ovf, 0);
      check("R10 unf kept", o_unf, 1);
      check("R9 err_irq unf", o_eirq, 1);

      // R11 flush keeps flags
      for (int k = 0; k < 3; k++) push(pat(k));
      do_flush();
      check("R11 level", o_level, 0);
      check("R11 rd_valid", o_rd_valid, 0);
      check("R11 unf kept", o_unf, 1);
      err_clr_wr = 1'b1;
      err_clr    = 2'b10;
      tick();
      err_clr_wr = 1'b0;
      check("R10 unf cleared", o_unf, 0);
      check("R9 err_irq off", o_eirq, 0);

      // R10 set wins over clear
      for (int k = 0; k < 32; k++) push(pat(k));
      wr_valid   = 1'b1;
      err_clr_wr = 1'b1;
      err_clr    = 2'b11;
      tick();
      wr_valid   = 1'b0;
      err_clr_wr = 1'b0;
      check("R10 set wins", o_ovf, 1);
      check("R10 unf clear", o_unf, 0);

      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule